// File: doc/BRIEF.md
# Supply-Good Startup Sequencer

This block brings a device up from power-on and from supply dips. It runs on a free-running oscillator clock and watches a single digital supply-good level that an external comparator produces. The level first passes through a two-flop synchronizer. While the supply is low, the sequencer holds the system in reset with the core clock gated off. Once the supply is good, it waits a programmable number of oscillator cycles for the clock source to settle. It then releases reset and enables the core clock.

The supply is watched in every state. A dip during the settling wait, or while the core runs, sends the machine straight back to the hold state. The wait then starts again from zero on the next rise. Every pass through the hold state sets a reset-cause bit that software can read and clear. The code start address is a fixed value that the core loads when reset is released. All outputs are plain control and status levels, with no streaming interface.

Top module: `pwrseq_top`

## Requirements
- R1: After the asynchronous power-up reset, the machine is in the hold state: `seq_state` = 2'b00, `sys_rst` = 1, `core_clk_en` = 0.
- R2: `supply_ok` passes through two synchronizing flops. A change that is stable before posedge k shows in `seq_state` after posedge k+2.
- R3: While the synchronized supply-good is 0, the machine stays in the hold state (2'b00) with reset asserted.
- R4: The settling state (2'b01) lasts exactly WAIT_CYC cycles with the supply good. The machine then enters the run state (2'b10).
- R5: A supply drop during settling returns the machine to the hold state. The next rise restarts the full WAIT_CYC-cycle wait from zero.
- R6: `core_clk_en` is 1 only in the run state. `sys_rst` is 1 in every state except the run state.
- R7: A supply drop in the run state, even a single cycle long, returns the machine to the hold state and asserts reset.
- R8: Bit 7 of the 8-bit `ctl_image` is the reset-cause flag. It is 1 after power-up reset and is set by every cycle spent in the hold state. Bits 6:0 are always 0.
- R9: A one-cycle `cause_clr` pulse clears the flag on the next edge, but only outside the hold state. In the hold state, setting wins. A clear never sets the flag, and leaving reset does not clear it.
- R10: `start_addr` always reads 16'h8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| arst_n | input | 1 | Asynchronous power-up reset, active low |
| supply_ok | input | 1 | Comparator level, 1 = supply above threshold (asynchronous) |
| cause_clr | input | 1 | Software write strobe that clears the reset-cause flag |
| core_clk_en | output | 1 | Core clock enable |
| sys_rst | output | 1 | System reset, active high |
| ctl_image | output | 8 | Control register image, bit 7 = reset-cause flag |
| start_addr | output | 16 | Code start address |
| seq_state | output | 2 | 00 hold, 01 settling, 10 run |

## Verification
The bench checks the exact edge on which each transition lands, counting the synchronizer latency. A design with one sync flop too many or too few would be off by one cycle. It checks the last settling cycle and the first run cycle. A counter that ends one early or one late, or that resumes instead of restarting after a mid-wait dip, would shift the run entry. It sends single-cycle dips in the run state and expects them to be caught. It also sends clear strobes in the hold state and in the run state. A flag whose clear overrode the set, or that cleared itself on reset release, would show the wrong bit 7.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [1:0] {
    ST_HOLD   = 2'b00,
    ST_SETTLE = 2'b01,
    ST_RUN    = 2'b10
  } seq_state_e;

  localparam int unsigned CTL_W      = 8;
  localparam int unsigned CAUSE_BIT  = 7;
  localparam int unsigned ADDR_W     = 16;
  localparam logic [15:0] BOOT_VEC   = 16'h8000;
endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int unsigned WAIT_CYC = 10000
) (
  input  logic clk,
  input  logic arst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = $clog2(WAIT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)  cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
    else          cnt <= '0;
  end

  assign done = run && (cnt == LAST);
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       sok,
  input  logic       wait_done,
  output seq_state_e state
);
  seq_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_HOLD:   if (sok) nxt = ST_SETTLE;
      ST_SETTLE: begin
        if (!sok)          nxt = ST_HOLD;
        else if (wait_done) nxt = ST_RUN;
      end
      ST_RUN:    if (!sok) nxt = ST_HOLD;
      default:   nxt = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) state <= ST_HOLD;
    else         state <= nxt;
  end
endmodule

// File: rtl/pwrseq_flag.sv
module pwrseq_flag (
  input  logic clk,
  input  logic arst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)    flag <= 1'b1;
    else if (set_i) flag <= 1'b1;
    else if (clr_i) flag <= 1'b0;
  end
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int unsigned WAIT_CYC    = 10000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        arst_n,
  input  logic        supply_ok,
  input  logic        cause_clr,
  output logic        core_clk_en,
  output logic        sys_rst,
  output logic [7:0]  ctl_image,
  output logic [15:0] start_addr,
  output logic [1:0]  seq_state
);
  logic       sok_s;
  logic       wait_done;
  logic       cause;
  seq_state_e state;

  pwrseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst_n(arst_n), .d_async(supply_ok), .q_sync(sok_s)
  );

  pwrseq_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk(clk), .arst_n(arst_n), .run(state == ST_SETTLE), .done(wait_done)
  );

  pwrseq_fsm u_fsm (
    .clk(clk), .arst_n(arst_n), .sok(sok_s), .wait_done(wait_done), .state(state)
  );

  pwrseq_flag u_flag (
    .clk(clk), .arst_n(arst_n), .set_i(state == ST_HOLD), .clr_i(cause_clr), .flag(cause)
  );

  assign core_clk_en = (state == ST_RUN);
  assign sys_rst     = (state != ST_RUN);
  assign seq_state   = state;
  assign start_addr  = BOOT_VEC;

  always_comb begin
    ctl_image            = '0;
    ctl_image[CAUSE_BIT] = cause;
  end
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk #(
  parameter int unsigned WAIT_CYC = 10000
) (
  input logic       clk,
  input logic       arst_n,
  input logic       sok,
  input logic [1:0] st,
  input logic       core_en,
  input logic       rst_o,
  input logic [7:0] img,
  input logic       clr
);
  localparam int unsigned CW = $clog2(WAIT_CYC + 2);
  logic [CW-1:0] settle_cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)          settle_cnt <= '0;
    else if (st == 2'b01) settle_cnt <= settle_cnt + 1'b1;
    else                  settle_cnt <= '0;
  end

  p_legal_code_r1: assert property (@(posedge clk) disable iff (!arst_n)
    st != 2'b11);

  p_enter_run_from_settle_r4: assert property (@(posedge clk) disable iff (!arst_n)
    (st == 2'b10 && $past(st) != 2'b10) |-> $past(st) == 2'b01);

  p_settle_len_r4: assert property (@(posedge clk) disable iff (!arst_n)
    (st == 2'b10 && $past(st) == 2'b01) |-> settle_cnt == CW'(WAIT_CYC));

  p_settle_bound_r4: assert property (@(posedge clk) disable iff (!arst_n)
    (st == 2'b01) |-> settle_cnt < CW'(WAIT_CYC));

  p_drop_to_hold_r5: assert property (@(posedge clk) disable iff (!arst_n)
    !sok |=> st == 2'b00);

  p_hold_while_low_r3: assert property (@(posedge clk) disable iff (!arst_n)
    (st == 2'b00 && !sok) |=> (st == 2'b00 && rst_o));

  p_en_excl_rst_r6: assert property (@(posedge clk) disable iff (!arst_n)
    core_en |-> !rst_o);

  p_hold_sets_flag_r8: assert property (@(posedge clk) disable iff (!arst_n)
    (st == 2'b00) |=> img[7]);

  p_low_bits_zero_r8: assert property (@(posedge clk) disable iff (!arst_n)
    img[6:0] == 7'd0);

  p_clear_works_r9: assert property (@(posedge clk) disable iff (!arst_n)
    (clr && st != 2'b00) |=> !img[7]);

  p_no_spurious_set_r9: assert property (@(posedge clk) disable iff (!arst_n)
    (img[7] && !$past(img[7])) |-> $past(st) == 2'b00);
endmodule

bind pwrseq_top pwrseq_chk #(.WAIT_CYC(WAIT_CYC)) chk_i (
  .clk(clk), .arst_n(arst_n), .sok(sok_s), .st(seq_state),
  .core_en(core_clk_en), .rst_o(sys_rst), .img(ctl_image), .clr(cause_clr)
);

// File: tb/pwrseq_top_tb_top.sv
module pwrseq_top_tb_top;
  localparam int N = 20;
  localparam int WDOG = 20000;

  typedef struct {
    int         cyc;
    logic [1:0] st;
    logic       fl;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        supply_ok = 1'b0;
  logic        cause_clr = 1'b0;
  logic        core_clk_en, sys_rst;
  logic [7:0]  ctl_image;
  logic [15:0] start_addr;
  logic [1:0]  seq_state;

  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  exp_t q[$];

  always #4 clk = ~clk;

  pwrseq_top #(.WAIT_CYC(N)) dut_i (
    .clk(clk), .arst_n(arst_n), .supply_ok(supply_ok), .cause_clr(cause_clr),
    .core_clk_en(core_clk_en), .sys_rst(sys_rst), .ctl_image(ctl_image),
    .start_addr(start_addr), .seq_state(seq_state)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int c, logic [1:0] st, logic fl, string tag);
    exp_t e;
    e.cyc = c; e.st = st; e.fl = fl; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    tick(1);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: compares scoreboard items on the falling edge of their cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      logic [7:0] img_x;
      e = q.pop_front();
      img_x = {e.fl, 7'd0};
      total++;
      if (e.cyc != cyc || seq_state !== e.st || sys_rst !== (e.st != 2'b10) ||
          core_clk_en !== (e.st == 2'b10) || ctl_image !== img_x) begin
        bad++;
        $display("FAIL %s cyc=%0d: state=%b rst=%b en=%b img=%h expected state=%b rst=%b en=%b img=%h",
                 e.tag, cyc, seq_state, sys_rst, core_clk_en, ctl_image,
                 e.st, (e.st != 2'b10), (e.st == 2'b10), img_x);
      end
      total++;
      if (start_addr !== 16'h8000) begin
        bad++;
        $display("FAIL R10 cyc=%0d: start_addr=%h expected 8000", cyc, start_addr);
      end
    end
  end

  initial begin
    wait (cyc >= WDOG);
    bad++; total++;
    $display("FAIL watchdog: cycles=%0d expected < %0d", cyc, WDOG);
    summary();
  end

  initial begin
    int c;
    tick(3);
    arst_n = 1'b1;
    // R1: hold state after power-up, flag set
    c = cyc; expect_at(c + 1, 2'b00, 1'b1, "R1 power-up hold");
    drain();
    // R9: clear ignored in hold state
    c = cyc; cause_clr = 1'b1; expect_at(c + 1, 2'b00, 1'b1, "R9 clr in hold");
    tick(1); cause_clr = 1'b0;
    // R3: remain in hold while supply low
    c = cyc; expect_at(c + 8, 2'b00, 1'b1, "R3 low supply hold");
    drain();
    // R2 R4 R6: rise -> settle after sync -> run after N cycles
    c = cyc; supply_ok = 1'b1;
    expect_at(c + 2, 2'b00, 1'b1, "R2 still hold in sync");
    expect_at(c + 3, 2'b01, 1'b1, "R2 settle after sync");
    expect_at(c + 2 + N, 2'b01, 1'b1, "R4 last settle cycle");
    expect_at(c + 3 + N, 2'b10, 1'b1, "R4 R6 run entry");
    drain();
    // R9: clear in run state, stays cleared
    c = cyc; cause_clr = 1'b1;
    expect_at(c + 1, 2'b10, 1'b0, "R9 clr in run");
    tick(1); cause_clr = 1'b0;
    expect_at(c + 6, 2'b10, 1'b0, "R9 stays clear");
    drain();
    // R7 R8: drop in run state
    c = cyc; supply_ok = 1'b0;
    expect_at(c + 2, 2'b10, 1'b0, "R7 before sync");
    expect_at(c + 3, 2'b00, 1'b0, "R7 hold entry");
    expect_at(c + 4, 2'b00, 1'b1, "R8 flag set");
    drain();
    // R5: drop mid-settle, then restart from zero
    c = cyc; supply_ok = 1'b1;
    expect_at(c + 3, 2'b01, 1'b1, "R5 settle");
    tick(11);
    c = cyc; supply_ok = 1'b0;
    expect_at(c + 2, 2'b01, 1'b1, "R5 settle before drop");
    expect_at(c + 3, 2'b00, 1'b1, "R5 back to hold");
    drain();
    tick(3);
    c = cyc; supply_ok = 1'b1;
    expect_at(c + 2 + N, 2'b01, 1'b1, "R5 full wait restart");
    expect_at(c + 3 + N, 2'b10, 1'b1, "R5 R9 run, flag kept");
    drain();
    // R7: single-cycle dip in run state
    c = cyc; supply_ok = 1'b0;
    tick(1); supply_ok = 1'b1;
    expect_at(c + 3, 2'b00, 1'b1, "R7 glitch caught");
    expect_at(c + 4, 2'b01, 1'b1, "R7 settle again");
    expect_at(c + 4 + N, 2'b10, 1'b1, "R7 R4 run again");
    drain();
    // R6 R1: power-up reset while running
    arst_n = 1'b0; tick(2); arst_n = 1'b1;
    c = cyc; supply_ok = 1'b0;
    expect_at(c + 1, 2'b00, 1'b1, "R1 re-reset hold");
    drain();
    summary();
  end
endmodule